// File: doc/BRIEF.md
# Edge-Triggered External Event Interrupt Controller

This block watches 32 external event lines and turns selected signal transitions into a single level-high interrupt toward a parent interrupt controller. Each line passes through a two-stage synchroniser. Its synchronised value is then compared with the value from the previous cycle to find rising and falling transitions. Every line has its own enable for rising transitions and its own enable for falling transitions. A line can therefore react to rising edges only, to falling edges only, or to both.

Captured transitions latch into two separate pending registers, one per polarity. Software clears a pending bit by writing 1 to it, and a write of 0 leaves the bit alone, so no read is needed before a clear. Software can also inject an event on any line through a trigger register, which is used to re-raise an interrupt that was lost. A per-line mask selects which pending lines drive the interrupt output. A per-line reservation register is stored for software and has no effect on event capture.

All access uses one simple 32-bit register port. Bit n of every per-line register belongs to line n. Read data is registered.

Top module: `eic_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The registers sit at these offsets: rising enable 0x00, falling enable 0x04, software trigger 0x08, rising pending 0x0C, falling pending 0x10, reservation 0x14, mask 0x80. Bit n of each register is line n. The enable, reservation and mask registers read back the last value written. Any other offset reads zero.
- R3: When a line's bit in the rising enable register is 1 and the line goes from 0 to 1, bit n of the rising pending register is set within four clock cycles. When that enable bit is 0, a rising transition leaves both pending registers unchanged.
- R4: When a line's bit in the falling enable register is 1 and the line goes from 1 to 0, bit n of the falling pending register is set. When that enable bit is 0, a falling transition leaves both pending registers unchanged.
- R5: When both enables of a line are set, each transition sets the pending register of its own polarity, and neither affects the other register.
- R6: Writing 1 to a bit of either pending register clears that bit. Writing 0 leaves the bit unchanged.
- R7: When a new event on a line and a write of 1 that clears the same pending bit fall on the same clock edge, the bit stays set.
- R8: Writing 1 to bit n at offset 0x08 sets bit n of the rising pending register, whatever the edge enables hold. Writing 0 has no effect. Offset 0x08 always reads zero.
- R9: `irq_o` is a registered copy of the OR over all lines of ((rising pending OR falling pending) AND mask). It stays high until software clears every pending bit that causes it.
- R10: A mask bit of 0 keeps its line from raising `irq_o`, but the line's events are still recorded in the pending registers. The mask can be written to all zeros.
- R11: The reservation register at 0x14 is plain read/write storage and has no effect on event capture.
- R12: A read returns the register value on the `bus_rdata` output after the clock edge that samples the read. That value is held until the next read, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_in | input | 32 | Asynchronous external event lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level-high interrupt toward the parent controller |

## Verification
Two functions can act on the same bit in one cycle: a hardware edge that sets a pending bit, and a software write of 1 that clears that bit. The bench first sets a pending bit through the software trigger. It then changes the event input and times a clearing write so that the write is sampled on the same clock edge at which the synchronised edge reaches the pending register. A following read must show the bit still set. Random sequences then mix input changes, clears, triggers and reconfiguration. Each result is compared with a bench model of the two pending registers and the interrupt level.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
    localparam int unsigned OFS_RISE_EN = 32'h000;
    localparam int unsigned OFS_FALL_EN = 32'h004;
    localparam int unsigned OFS_SWTRIG  = 32'h008;
    localparam int unsigned OFS_RPEND   = 32'h00C;
    localparam int unsigned OFS_FPEND   = 32'h010;
    localparam int unsigned OFS_RESV    = 32'h014;
    localparam int unsigned OFS_MASK    = 32'h080;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RISE_EN,
        SEL_FALL_EN,
        SEL_SWTRIG,
        SEL_RPEND,
        SEL_FPEND,
        SEL_RESV,
        SEL_MASK
    } reg_sel_e;
endpackage

// File: rtl/eic_sync.sv
`timescale 1ns/1ps
module eic_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/eic_edge_capture.sv
`timescale 1ns/1ps
module eic_edge_capture #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic [NUM_LINES-1:0] rise_en_i,
    input  logic [NUM_LINES-1:0] fall_en_i,
    input  logic [NUM_LINES-1:0] sw_set_i,
    input  logic [NUM_LINES-1:0] rclr_i,
    input  logic [NUM_LINES-1:0] fclr_i,
    output logic [NUM_LINES-1:0] rpend_o,
    output logic [NUM_LINES-1:0] fpend_o
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] rise_evt;
    logic [NUM_LINES-1:0] fall_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    always_comb begin
        rise_evt = (level_i & ~prev_q & rise_en_i) | sw_set_i;
        fall_evt = (~level_i & prev_q & fall_en_i);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic rp_q;
        logic fp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rp_q <= 1'b0;
                fp_q <= 1'b0;
            end else begin
                if (rise_evt[i])    rp_q <= 1'b1;
                else if (rclr_i[i]) rp_q <= 1'b0;
                if (fall_evt[i])    fp_q <= 1'b1;
                else if (fclr_i[i]) fp_q <= 1'b0;
            end
        end
        assign rpend_o[i] = rp_q;
        assign fpend_o[i] = fp_q;
    end

    // R6: a clear without a competing event empties the bit
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rclr_i & ~rise_evt)) |=> ((rpend_o & $past(rclr_i & ~rise_evt)) == '0));
    // R7: an event always leaves its bit set, even against a clear
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_evt) |=> ((rpend_o & $past(rise_evt)) == $past(rise_evt)));
    // R6: with no event and no clear, pending holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_evt | rclr_i | fall_evt | fclr_i) == '0) |=> ($stable(rpend_o) && $stable(fpend_o)));
endmodule

// File: rtl/eic_regfile.sv
`timescale 1ns/1ps
module eic_regfile
    import eic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_LINES-1:0] rpend_i,
    input  logic [NUM_LINES-1:0] fpend_i,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] rise_en_o,
    output logic [NUM_LINES-1:0] fall_en_o,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] sw_set_o,
    output logic [NUM_LINES-1:0] rclr_o,
    output logic [NUM_LINES-1:0] fclr_o
);
    logic [NUM_LINES-1:0] resv_q;
    logic [NUM_LINES-1:0] wline;
    logic [DATA_W-1:0]    rd_mux;
    logic                 wr_hit;
    logic                 rd_hit;
    reg_sel_e             sel;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_RISE_EN)) sel = SEL_RISE_EN;
        else if (bus_addr == ADDR_W'(OFS_FALL_EN)) sel = SEL_FALL_EN;
        else if (bus_addr == ADDR_W'(OFS_SWTRIG))  sel = SEL_SWTRIG;
        else if (bus_addr == ADDR_W'(OFS_RPEND))   sel = SEL_RPEND;
        else if (bus_addr == ADDR_W'(OFS_FPEND))   sel = SEL_FPEND;
        else if (bus_addr == ADDR_W'(OFS_RESV))    sel = SEL_RESV;
        else if (bus_addr == ADDR_W'(OFS_MASK))    sel = SEL_MASK;
        else                                       sel = SEL_NONE;
    end

    assign wr_hit = bus_sel & bus_wr;
    assign rd_hit = bus_sel & ~bus_wr;
    assign wline  = bus_wdata[NUM_LINES-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_o <= '0;
            fall_en_o <= '0;
            resv_q    <= '0;
            mask_o    <= '0;
        end else if (wr_hit) begin
            unique case (sel)
                SEL_RISE_EN: rise_en_o <= wline;
                SEL_FALL_EN: fall_en_o <= wline;
                SEL_RESV:    resv_q    <= wline;
                SEL_MASK:    mask_o    <= wline;
                default:     ;
            endcase
        end
    end

    always_comb begin
        sw_set_o = '0;
        rclr_o   = '0;
        fclr_o   = '0;
        if (wr_hit) begin
            unique case (sel)
                SEL_SWTRIG: sw_set_o = wline;
                SEL_RPEND:  rclr_o   = wline;
                SEL_FPEND:  fclr_o   = wline;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RISE_EN: rd_mux = DATA_W'(rise_en_o);
            SEL_FALL_EN: rd_mux = DATA_W'(fall_en_o);
            SEL_RPEND:   rd_mux = DATA_W'(rpend_i);
            SEL_FPEND:   rd_mux = DATA_W'(fpend_i);
            SEL_RESV:    rd_mux = DATA_W'(resv_q);
            SEL_MASK:    rd_mux = DATA_W'(mask_o);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_hit) bus_rdata <= rd_mux;
    end

    // R12: read data only moves on a read
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(bus_rdata));
    // R10: a mask write lands in the mask one cycle later
    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == SEL_MASK) |=> (mask_o == $past(wline)));
    // R8: software trigger never reads back non-zero
    p_swtrig_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && sel == SEL_SWTRIG) |=> (bus_rdata == '0));
endmodule

// File: rtl/eic_top.sv
`timescale 1ns/1ps
module eic_top #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ev_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] rise_en;
    logic [NUM_LINES-1:0] fall_en;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] sw_set;
    logic [NUM_LINES-1:0] rclr;
    logic [NUM_LINES-1:0] fclr;
    logic [NUM_LINES-1:0] rpend;
    logic [NUM_LINES-1:0] fpend;
    logic                 irq_d;

    eic_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ev_in), .sync_o(level)
    );

    eic_edge_capture #(.NUM_LINES(NUM_LINES)) u_capture (
        .clk(clk), .rst_n(rst_n), .level_i(level),
        .rise_en_i(rise_en), .fall_en_i(fall_en), .sw_set_i(sw_set),
        .rclr_i(rclr), .fclr_i(fclr), .rpend_o(rpend), .fpend_o(fpend)
    );

    eic_regfile #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rpend_i(rpend), .fpend_i(fpend), .bus_rdata(bus_rdata),
        .rise_en_o(rise_en), .fall_en_o(fall_en), .mask_o(mask),
        .sw_set_o(sw_set), .rclr_o(rclr), .fclr_o(fclr)
    );

    assign irq_d = |((rpend | fpend) & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_d;
    end

    // R9: an unmasked pending line raises the output on the next cycle
    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|((rpend | fpend) & mask)) |=> irq_o);
    // R10: nothing unmasked pending keeps the output low next cycle
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (((rpend | fpend) & mask) == '0) |=> !irq_o);
endmodule

// File: tb/sim_eic_top.sv
`timescale 1ns/1ps
module sim_eic_top;
    localparam int unsigned A_REN = 12'h000, A_FEN = 12'h004, A_SWT = 12'h008,
                            A_RP  = 12'h00C, A_FP  = 12'h010, A_RSV = 12'h014,
                            A_MSK = 12'h080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ev_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [31:0] m_ren = '0, m_fen = '0, m_msk = '0, m_rp = '0, m_fp = '0, m_in = '0;

    always #5 clk = ~clk;

    eic_top u0 (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] f_rise(logic [31:0] o, logic [31:0] n, logic [31:0] en);
        return n & ~o & en;
    endfunction
    function automatic logic [31:0] f_fall(logic [31:0] o, logic [31:0] n, logic [31:0] en);
        return ~n & o & en;
    endfunction
    function automatic logic f_irq(logic [31:0] rp, logic [31:0] fp, logic [31:0] m);
        return |((rp | fp) & m);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive_in(logic [31:0] v);
        ev_in = v;
        repeat (6) @(negedge clk);
        m_rp |= f_rise(m_in, v, m_ren);
        m_fp |= f_fall(m_in, v, m_fen);
        m_in = v;
    endtask

    task automatic check_state(string tag);
        logic [31:0] d;
        bus_read(12'(A_RP), d); check({tag, " rising pending"}, d, m_rp);
        bus_read(12'(A_FP), d); check({tag, " falling pending"}, d, m_fp);
        repeat (2) @(negedge clk);
        check({tag, " irq"}, 32'(irq_o), 32'(f_irq(m_rp, m_fp, m_msk)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", 32'(irq_o), 32'd0);
        bus_read(12'(A_REN), d); check("R1 rise enable", d, 0);
        bus_read(12'(A_MSK), d); check("R1 mask", d, 0);
        bus_read(12'(A_RP), d);  check("R1 rising pending", d, 0);
        bus_read(12'(A_RSV), d); check("R1 reservation", d, 0);

        // R2: map and readback
        bus_write(12'(A_REN), 32'hA5A5_0F0F); bus_read(12'(A_REN), d); check("R2 rise enable readback", d, 32'hA5A5_0F0F);
        bus_write(12'(A_FEN), 32'h1234_8001); bus_read(12'(A_FEN), d); check("R2 fall enable readback", d, 32'h1234_8001);
        bus_read(12'h040, d); check("R2 unmapped offset", d, 0);
        bus_write(12'(A_REN), 0); bus_write(12'(A_FEN), 0);

        // R3 R4 R5: line3 rise only, line5 fall only, line7 both, line9 none
        m_ren = 32'h88; m_fen = 32'hA0;
        bus_write(12'(A_REN), m_ren); bus_write(12'(A_FEN), m_fen);
        drive_in(32'h2A8);
        check_state("R3 R5 rise pass");
        drive_in(32'h000);
        check_state("R4 R5 fall pass");
        check("R5 both-edge line in each register", {30'd0, m_rp[7], m_fp[7]}, 32'd3);

        // R6: write 0 no effect, write 1 clears
        bus_write(12'(A_RP), 0); check_state("R6 zero write");
        bus_write(12'(A_RP), 32'h8); m_rp &= ~32'h8; check_state("R6 clear rising bit");
        bus_write(12'(A_FP), 32'hFFFF_FFFF); m_fp = 0;
        bus_write(12'(A_RP), 32'hFFFF_FFFF); m_rp = 0; check_state("R6 clear all");

        // R8: software trigger ignores enables
        m_ren = 0; m_fen = 0; bus_write(12'(A_REN), 0); bus_write(12'(A_FEN), 0);
        bus_write(12'(A_SWT), 32'h200); m_rp |= 32'h200; check_state("R8 software trigger");
        bus_read(12'(A_SWT), d); check("R8 trigger reads zero", d, 0);
        bus_write(12'(A_SWT), 0); check_state("R8 zero trigger");

        // R9 R10: masking
        check("R10 masked pending keeps irq low", 32'(irq_o), 0);
        m_msk = 32'h200; bus_write(12'(A_MSK), m_msk); check_state("R9 unmasked raises irq");
        check("R9 irq level high", 32'(irq_o), 1);
        bus_write(12'(A_RP), 32'h200); m_rp = 0; check_state("R9 clear drops irq");
        m_msk = 0; bus_write(12'(A_MSK), 0);

        // R11: reservation is storage only
        bus_write(12'(A_RSV), 32'hFFFF_FFFF); bus_read(12'(A_RSV), d); check("R11 reservation readback", d, 32'hFFFF_FFFF);
        m_ren = 32'h1; bus_write(12'(A_REN), m_ren);
        drive_in(32'h1); check_state("R11 capture unaffected");
        bus_write(12'(A_RP), 32'h1); m_rp = 0;

        // R12: read data held across a write
        bus_read(12'(A_RSV), d);
        bus_write(12'(A_MSK), 0);
        @(negedge clk);
        check("R12 read data held", bus_rdata, 32'hFFFF_FFFF);

        // R7: edge and clear on the same edge
        m_ren = 32'h4; bus_write(12'(A_REN), m_ren);
        bus_write(12'(A_SWT), 32'h4); m_rp |= 32'h4;
        ev_in = m_in | 32'h4;
        @(negedge clk); @(negedge clk);
        bus_write(12'(A_RP), 32'h4);
        repeat (4) @(negedge clk);
        m_in = ev_in;
        check_state("R7 event wins over clear");
        bus_write(12'(A_RP), 32'h4); m_rp &= ~32'h4; check_state("R7 later clear");

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            case ($urandom_range(0, 4))
                0, 1: drive_in(r);
                2: begin bus_write(($urandom_range(0, 1) != 0) ? 12'(A_RP) : 12'(A_FP), r);
                       if (bus_addr == 12'(A_RP)) m_rp &= ~r; else m_fp &= ~r; end
                3: begin bus_write(12'(A_SWT), r & $urandom); m_rp |= bus_wdata; end
                default: begin
                    m_ren = r; m_fen = $urandom; m_msk = $urandom;
                    bus_write(12'(A_REN), m_ren); bus_write(12'(A_FEN), m_fen); bus_write(12'(A_MSK), m_msk);
                end
            endcase
            check_state("R3 R4 R6 R8 R9 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule